// File: doc/BRIEF.md
# Frame-Synced Codec Serial Port with Register Frames

This block is the converter-side end of a synchronous serial link to a signal processor. One bit clock and one active-low frame sync carry two kinds of 16-bit frame. A primary frame moves one sample word each way: `tx_sample` is shifted out on `sdo` and the word arriving on `sdi` is presented as `rx_sample`. A secondary frame carries control traffic for a small bank of 8-bit registers. Each bit goes out on a rising clock edge and comes in on a falling edge, MSB first.

The frame sync can be produced by the block (master) or taken from the link (slave), chosen by `mstr_en`, which is held steady while out of reset. The processor asks for a secondary frame either with the `sec_req` pin, sampled at the edge that ends a primary frame, or by setting the LSB of the primary word it sends. The secondary frame is the next frame on the link, and a primary frame follows it. A mode register at address 2 turns on a bypass option: during secondary frames `sdo` carries `bypass_in` instead of the register reply, and `ctl_flag` shows a bit of the same register.

Top module: `codec_serial_port`

## Requirements
- R1: `sdo_oe` is 1 exactly while a frame is active, meaning the frame sync sampled at the previous rising edge was low. It is 0 when idle and in reset.
- R2: In a primary frame, `tx_sample` is latched at the rising edge that first samples frame sync low. Bit 15 is driven at that edge, and bit 15-k is driven at the k-th rising edge after it.
- R3: `sdi` is captured on the falling edge while the frame is active. At the rising edge that samples frame sync high after a primary frame, `rx_sample` is updated with the 16 bits received, MSB first, and `rx_valid` pulses high for one cycle.
- R4: A secondary frame becomes pending if `sec_req` is 1 at the rising edge that ends a primary frame, or if bit 0 of the received primary word is 1. The next frame is then secondary, and the frame after it is primary.
- R5: Secondary input word: bit 15 = 1 for a read, 0 for a write; bits 12:8 = register address; bits 7:0 = write data. A write takes effect at the end of the frame. A write to an address of 8 or above changes nothing, and such addresses read as 0.
- R6: Secondary output word: bits 15:8 are 0, and bits 7:0 are the addressed register as it was before that frame's write.
- R7: In master mode `fs_oe` is 1 and `fs_out` falls every 128 clocks, staying low for 16 clocks. In slave mode `fs_oe` is 0. After reset `fs_out` is 1.
- R8: In master mode a pending secondary frame begins 64 clocks after the start of the primary frame that requested it.
- R9: When bit 0 of register 2 is 1 (bypass), `sdo` equals `bypass_in` during secondary frames. Primary frames are unaffected.
- R10: `ctl_flag` equals bit 1 of register 2 when bypass is on, and 0 otherwise. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mstr_en | input | 1 | 1 = generate frame sync, 0 = accept it |
| fs_in | input | 1 | External frame sync, active low (slave) |
| fs_out | output | 1 | Generated frame sync, active low (master) |
| fs_oe | output | 1 | Enable for the frame sync driver |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Enable for the data-out driver |
| sec_req | input | 1 | Secondary frame request |
| bypass_in | input | 1 | Data routed to `sdo` in secondary frames while bypass is on |
| ctl_flag | output | 1 | Flag from register 2 while bypass is on |
| tx_sample | input | 16 | Sample word to transmit |
| rx_sample | output | 16 | Last received sample word |
| rx_valid | output | 1 | One-cycle pulse when `rx_sample` updates |

## Verification
The bench uses the default parameters: a 128-clock master period, a 64-clock secondary offset and eight registers. With these values the master spacing of primary and secondary starts can be measured directly. Addresses 8 and 9 also lie past the implemented bank, so a write there would land on registers 0 and 1 if the address were folded. Slave frames carry random words and register traffic, and directed frames cover the word-LSB request, bypass on and off, and the flag.

// File: rtl/csp_pkg.sv
package csp_pkg;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic       rd;
    logic [1:0] rsvd;
    logic [4:0] addr;
    logic [7:0] data;
  } sec_word_t;

  function automatic logic in_window(int pos, int start, int len);
    return (pos >= start) && (pos < start + len);
  endfunction

  function automatic logic req_in_word(logic [WORD_W-1:0] w);
    return w[0];
  endfunction

  function automatic logic [WORD_W-1:0] sec_reply(logic [7:0] v);
    return {8'h00, v};
  endfunction
endpackage

// File: rtl/csp_fs_timer.sv
module csp_fs_timer #(
  parameter int PERIOD    = 128,
  parameter int FRAME_LEN = 16,
  parameter int SEC_OFS   = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sec_hold,
  output logic fs_gen_n
);
  import csp_pkg::*;
  localparam int CW = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt, cnt_n;

  assign cnt_n = (cnt == LAST) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= LAST;
    else if (!en) cnt <= LAST;
    else          cnt <= cnt_n;
  end

  assign fs_gen_n = !(in_window(int'(cnt_n), 0, FRAME_LEN) ||
                      (sec_hold && in_window(int'(cnt_n), SEC_OFS, FRAME_LEN)));
endmodule

// File: rtl/csp_shifter.sv
module csp_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         inj,
  input  logic [7:0]   inj_byte,
  input  logic         shift_en,
  input  logic         cap_en,
  input  logic         sdi,
  output logic         tx_bit,
  output logic [W-1:0] rx_word
);
  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_bit <= 1'b0;
      sh     <= '0;
    end else if (load) begin
      tx_bit <= load_word[W-1];
      sh     <= load_word << 1;
    end else if (inj) begin
      tx_bit <= inj_byte[7];
      sh     <= {inj_byte[6:0], {(W-7){1'b0}}};
    end else if (shift_en) begin
      tx_bit <= sh[W-1];
      sh     <= sh << 1;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)      rx_word <= '0;
    else if (cap_en) rx_word <= {rx_word[W-2:0], sdi};
  end
endmodule

// File: rtl/csp_regs.sv
module csp_regs #(
  parameter int NREG      = 8,
  parameter int MODE_ADDR = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [4:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [4:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       bypass_en,
  output logic       flag_bit
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [7:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           regs[i] <= '0;
      else if (we && int'(wr_addr) == i)    regs[i] <= wr_data;
    end
  end

  assign rd_data   = (int'(rd_addr) < NREG) ? regs[rd_addr[IW-1:0]] : 8'h00;
  assign bypass_en = regs[MODE_ADDR][0];
  assign flag_bit  = regs[MODE_ADDR][1];
endmodule

// File: rtl/codec_serial_port.sv
module codec_serial_port #(
  parameter int PERIOD    = 128,
  parameter int FRAME_LEN = 16,
  parameter int SEC_OFS   = 64,
  parameter int NREG      = 8,
  parameter int MODE_ADDR = 2
) (
  input  logic        bit_clk,
  input  logic        rst_n,
  input  logic        mstr_en,
  input  logic        fs_in,
  output logic        fs_out,
  output logic        fs_oe,
  input  logic        sdi,
  output logic        sdo,
  output logic        sdo_oe,
  input  logic        sec_req,
  input  logic        bypass_in,
  output logic        ctl_flag,
  input  logic [15:0] tx_sample,
  output logic [15:0] rx_sample,
  output logic        rx_valid
);
  import csp_pkg::*;
  localparam int PW = $clog2(WORD_W) + 1;
  localparam logic [PW-1:0] INJ_POS = PW'(WORD_W / 2);

  logic fs_q, fs_now, fs_gen_n;
  logic sec_pend, sec_act;
  logic frm_start, frm_end, pri_start, sec_start, pri_end, sec_end;
  logic shift_en, inj, tx_bit;
  logic [PW-1:0] pos_idx;
  logic [WORD_W-1:0] rx_word, load_word;
  logic [7:0] rd_data;
  logic bypass_en, flag_bit;
  sec_word_t sw;

  csp_fs_timer #(.PERIOD(PERIOD), .FRAME_LEN(FRAME_LEN), .SEC_OFS(SEC_OFS)) u_timer (
    .clk(bit_clk), .rst_n(rst_n), .en(mstr_en),
    .sec_hold(sec_pend | sec_act), .fs_gen_n(fs_gen_n));

  assign fs_now    = mstr_en ? fs_gen_n : fs_in;
  assign frm_start = fs_q && !fs_now;
  assign frm_end   = !fs_q && fs_now;
  assign pri_start = frm_start && !sec_pend;
  assign sec_start = frm_start && sec_pend;
  assign pri_end   = frm_end && !sec_act;
  assign sec_end   = frm_end && sec_act;
  assign shift_en  = !fs_q && !fs_now;
  assign inj       = shift_en && sec_act && (pos_idx == INJ_POS);
  assign sw        = sec_word_t'(rx_word);
  assign load_word = pri_start ? tx_sample : sec_reply(8'h00);

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q      <= 1'b1;
      sec_pend  <= 1'b0;
      sec_act   <= 1'b0;
      pos_idx   <= '0;
      rx_sample <= '0;
      rx_valid  <= 1'b0;
    end else begin
      fs_q     <= fs_now;
      rx_valid <= pri_end;
      if (frm_start)                              pos_idx <= PW'(1);
      else if (shift_en && pos_idx != '1)         pos_idx <= pos_idx + 1'b1;
      if (sec_start)                              sec_act <= 1'b1;
      else if (frm_end)                           sec_act <= 1'b0;
      if (sec_start)                              sec_pend <= 1'b0;
      else if (pri_end && (sec_req || req_in_word(rx_word))) sec_pend <= 1'b1;
      if (pri_end)                                rx_sample <= rx_word;
    end
  end

  csp_shifter #(.W(WORD_W)) u_shift (
    .clk(bit_clk), .rst_n(rst_n), .load(frm_start), .load_word(load_word),
    .inj(inj), .inj_byte(rd_data), .shift_en(shift_en),
    .cap_en(!fs_q), .sdi(sdi), .tx_bit(tx_bit), .rx_word(rx_word));

  csp_regs #(.NREG(NREG), .MODE_ADDR(MODE_ADDR)) u_regs (
    .clk(bit_clk), .rst_n(rst_n),
    .we(sec_end && !sw.rd), .wr_addr(sw.addr), .wr_data(sw.data),
    .rd_addr(rx_word[4:0]), .rd_data(rd_data),
    .bypass_en(bypass_en), .flag_bit(flag_bit));

  assign fs_out   = fs_q;
  assign fs_oe    = mstr_en;
  assign sdo_oe   = !fs_q;
  assign sdo      = (sec_act && bypass_en) ? bypass_in : tx_bit;
  assign ctl_flag = bypass_en && flag_bit;
endmodule

// File: rtl/csp_checker.sv
module csp_checker #(
  parameter int FRAME_LEN = 16,
  parameter int SEC_OFS   = 64
) (
  input logic bit_clk,
  input logic rst_n,
  input logic mstr_en,
  input logic fs_in,
  input logic fs_out,
  input logic sdo_oe,
  input logic rx_valid,
  input logic sec_req,
  input logic ctl_flag,
  input logic bypass_en,
  input logic pri_start,
  input logic pri_end,
  input logic sec_start,
  input logic sec_pend
);
  logic [7:0]  lo_cnt;
  logic [15:0] gap;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      gap    <= '0;
    end else begin
      if (fs_out)               lo_cnt <= '0;
      else if (lo_cnt != '1)    lo_cnt <= lo_cnt + 1'b1;
      if (pri_start)            gap <= 16'd1;
      else if (gap != '1)       gap <= gap + 1'b1;
    end
  end

  AST_OE_TRACKS_FS: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !mstr_en |=> (sdo_oe == !$past(fs_in)));                        // R1
  AST_RXV_AT_END: assert property (@(posedge bit_clk) disable iff (!rst_n)
    rx_valid |-> (!sdo_oe && $past(sdo_oe)));                       // R3
  AST_REQ_LATCHED: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (pri_end && sec_req) |=> sec_pend);                             // R4
  AST_MASTER_LOW_LEN: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (mstr_en && $rose(fs_out)) |-> (int'(lo_cnt) == FRAME_LEN));    // R7
  AST_SEC_GAP: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (mstr_en && sec_start) |-> (int'(gap) == SEC_OFS));             // R8
  AST_FLAG_NEEDS_BYPASS: assert property (@(posedge bit_clk) disable iff (!rst_n)
    ctl_flag |-> bypass_en);                                        // R10
endmodule

bind codec_serial_port csp_checker #(.FRAME_LEN(FRAME_LEN), .SEC_OFS(SEC_OFS)) u_chk (
  .bit_clk(bit_clk), .rst_n(rst_n), .mstr_en(mstr_en), .fs_in(fs_in),
  .fs_out(fs_out), .sdo_oe(sdo_oe), .rx_valid(rx_valid), .sec_req(sec_req),
  .ctl_flag(ctl_flag), .bypass_en(bypass_en), .pri_start(pri_start),
  .pri_end(pri_end), .sec_start(sec_start), .sec_pend(sec_pend));

// File: tb/codec_serial_port_tb.sv
module codec_serial_port_tb;
  logic bit_clk = 1'b0;
  logic rst_n = 1'b0;
  logic mstr_en = 1'b0, fs_in = 1'b1, sdi = 1'b0, sec_req = 1'b0, bypass_in = 1'b0;
  logic [15:0] tx_sample = '0;
  logic fs_out, fs_oe, sdo, sdo_oe, ctl_flag, rx_valid;
  logic [15:0] rx_sample;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mdl [8];
  bit done = 0;

  always #4 bit_clk = ~bit_clk;

  codec_serial_port u_dut (
    .bit_clk(bit_clk), .rst_n(rst_n), .mstr_en(mstr_en), .fs_in(fs_in),
    .fs_out(fs_out), .fs_oe(fs_oe), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
    .sec_req(sec_req), .bypass_in(bypass_in), .ctl_flag(ctl_flag),
    .tx_sample(tx_sample), .rx_sample(rx_sample), .rx_valid(rx_valid));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mread(input logic [4:0] a);
    return (a < 5'd8) ? mdl[a[2:0]] : 8'h00;
  endfunction

  function automatic logic [15:0] mk_sec(input logic rd, input logic [4:0] a, input logic [7:0] d);
    return {rd, 2'b00, a, d};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(posedge bit_clk);
    #1;
  endtask

  // slave frame: returns bits seen on sdo and bits driven on bypass_in
  task automatic run_frame(input logic [15:0] w, input logic req,
                           output logic [15:0] got, output logic [15:0] alt);
    @(negedge bit_clk); #1 fs_in = 1'b0;
    for (int k = 0; k < 16; k++) begin
      @(posedge bit_clk); #1;
      sdi = w[15-k];
      bypass_in = 1'($urandom);
      alt[15-k] = bypass_in;
      #1 got[15-k] = sdo;
      if (k == 0 || k == 15) chk(sdo_oe === 1'b1, "R1 oe in frame", 32'(sdo_oe), 1);
    end
    @(negedge bit_clk); #1 fs_in = 1'b1; sec_req = req;
    @(posedge bit_clk); #1 sec_req = 1'b0;
    chk(sdo_oe === 1'b0, "R1 oe after frame", 32'(sdo_oe), 0);
  endtask

  task automatic sec_op(input logic rd, input logic [4:0] a, input logic [7:0] d);
    logic [15:0] g, al, exp;
    logic byp;
    tx_sample = 16'($urandom);
    run_frame(16'h0000, 1'b1, g, al);
    chk(g === tx_sample, "R2 primary before sec", 32'(g), 32'(tx_sample));
    idle(2);
    byp = mdl[2][0];
    run_frame(mk_sec(rd, a, d), 1'b0, g, al);
    exp = byp ? al : {8'h00, mread(a)};
    chk(g === exp, byp ? "R9 bypass reply" : "R6 sec reply", 32'(g), 32'(exp));
    chk(rx_valid === 1'b0, "R3 no rx_valid on sec", 32'(rx_valid), 0);
    if (!rd && a < 5'd8) mdl[a[2:0]] = d;
    idle(2);
    chk(ctl_flag === (mdl[2][0] & mdl[2][1]), "R10 flag", 32'(ctl_flag), 32'(mdl[2][0] & mdl[2][1]));
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] g, al, w;
    int falls [4];
    int nf, bidx, cyc;
    logic prev, fs, rx_checked;
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    void'($urandom(32'd2024));

    // reset state
    repeat (3) @(posedge bit_clk); #1;
    chk(sdo_oe === 1'b0, "R1 reset oe", 32'(sdo_oe), 0);
    chk(fs_out === 1'b1, "R7 reset fs_out", 32'(fs_out), 1);
    chk(rx_valid === 1'b0, "R3 reset rx_valid", 32'(rx_valid), 0);
    chk(ctl_flag === 1'b0, "R10 reset flag", 32'(ctl_flag), 0);
    rst_n = 1'b1;
    idle(3);
    chk(fs_oe === 1'b0, "R7 slave fs_oe", 32'(fs_oe), 0);
    chk(sdo_oe === 1'b0, "R1 idle oe", 32'(sdo_oe), 0);

    // random primary frames
    for (int i = 0; i < 20; i++) begin
      tx_sample = 16'($urandom);
      w = 16'($urandom) & 16'hFFFE;
      run_frame(w, 1'b0, g, al);
      chk(g === tx_sample, "R2 primary tx", 32'(g), 32'(tx_sample));
      chk(rx_valid === 1'b1, "R3 rx_valid pulse", 32'(rx_valid), 1);
      chk(rx_sample === w, "R3 rx word", 32'(rx_sample), 32'(w));
      idle(1);
      chk(rx_valid === 1'b0, "R3 rx_valid one cycle", 32'(rx_valid), 0);
      idle(1 + i % 3);
    end

    // register traffic, random and directed
    sec_op(1'b1, 5'd2, 8'h00);
    for (int i = 0; i < 24; i++) begin
      logic [4:0] a;
      a = 5'($urandom % 10);
      if (a == 5'd2) a = 5'd3;
      sec_op(1'($urandom), a, 8'($urandom));
    end
    sec_op(1'b0, 5'd1, 8'h3C);
    sec_op(1'b0, 5'd9, 8'h5A);   // R5 out of range write ignored
    sec_op(1'b1, 5'd9, 8'h00);
    sec_op(1'b1, 5'd1, 8'h00);
    sec_op(1'b0, 5'd0, 8'hC3);
    sec_op(1'b0, 5'd0, 8'h11);   // R6 reply shows value before write
    sec_op(1'b1, 5'd0, 8'h00);

    // R4: request through LSB of received primary word
    tx_sample = 16'hFFFF;
    run_frame(16'h8001, 1'b0, g, al);
    chk(g === 16'hFFFF, "R4 primary before lsb req", 32'(g), 32'hFFFF);
    idle(2);
    run_frame(mk_sec(1'b1, 5'd1, 8'h00), 1'b0, g, al);
    chk(g === {8'h00, mdl[1]}, "R4 lsb req gives sec", 32'(g), 32'({8'h00, mdl[1]}));
    idle(2);
    run_frame(16'h0000, 1'b0, g, al);
    chk(g === 16'hFFFF, "R4 primary after sec", 32'(g), 32'hFFFF);
    idle(2);

    // bypass mode and flag
    sec_op(1'b0, 5'd2, 8'h03);
    chk(ctl_flag === 1'b1, "R10 flag on", 32'(ctl_flag), 1);
    sec_op(1'b1, 5'd1, 8'h00);   // R9 reply replaced by bypass_in
    tx_sample = 16'h6A59;
    run_frame(16'h0000, 1'b0, g, al);
    chk(g === 16'h6A59, "R9 primary unaffected", 32'(g), 32'h6A59);
    idle(2);
    sec_op(1'b0, 5'd2, 8'h02);
    chk(ctl_flag === 1'b0, "R10 flag off without bypass", 32'(ctl_flag), 0);
    sec_op(1'b1, 5'd2, 8'h00);

    // master mode
    rst_n = 1'b0; mstr_en = 1'b1; sec_req = 1'b1; tx_sample = 16'hA5C3;
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    idle(2);
    chk(fs_oe === 1'b1, "R7 master fs_oe", 32'(fs_oe), 1);
    w = 16'h1234;
    nf = 0; bidx = 16; prev = 1'b1; rx_checked = 1'b0; g = '0;
    @(negedge bit_clk); rst_n = 1'b1;
    for (int c = 0; c < 420; c++) begin
      @(posedge bit_clk); #1;
      cyc = c;
      fs = fs_out;
      if (prev && !fs) begin
        if (nf < 4) falls[nf] = cyc;
        nf++;
        bidx = 0;
      end
      if (!fs && bidx < 16) begin
        if (nf == 1) begin
          g[15-bidx] = sdo;
          sdi = w[15-bidx];
        end else sdi = 1'b0;
        bidx++;
      end
      if (!prev && fs && nf == 1 && !rx_checked) begin
        sec_req = 1'b0;
        rx_checked = 1'b1;
        chk(rx_sample === w, "R3 master rx word", 32'(rx_sample), 32'(w));
      end
      prev = fs;
    end
    chk(g === 16'hA5C3, "R2 master tx", 32'(g), 32'hA5C3);
    chk(nf >= 4, "R7 master frame count", 32'(nf), 4);
    if (nf >= 4) begin
      chk(falls[1] - falls[0] == 64, "R8 sec offset", 32'(falls[1] - falls[0]), 64);
      chk(falls[2] - falls[0] == 128, "R7 period", 32'(falls[2] - falls[0]), 128);
      chk(falls[3] - falls[2] == 128, "R7 period no sec", 32'(falls[3] - falls[2]), 128);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule